// File: doc/BRIEF.md
# Strided Vector Load/Store Unit

This block moves whole vectors between a word-interleaved memory of sixteen banks and an internal file of eight vector registers, each holding up to 64 elements of 64 bits. A command names the operation, a base word address and a vector register. The number of elements comes from a programmable length register. The word distance between neighbouring elements comes from a programmable stride register. Element addresses are formed as base plus index times stride. The low four bits of an address select the bank, and the remaining upper bits form the address inside that bank.

Each bank stays occupied for eleven cycles per access. The unit keeps one busy counter per bank. It offers at most one element per cycle, in index order, and holds the next element back while its target bank is still occupied. Accesses to different banks overlap in time. A vector whose elements never return to an occupied bank therefore finishes in the bank latency plus the length minus one cycles. A stride equal to the bank count sends every element to the same bank, so the elements are serialised eleven cycles apart.

Each bank has its own request valid and its own read-return valid and data. The write-enable, in-bank address and write data are shared by all banks, because only one bank is addressed in any cycle. A memory bank returns read data with its return valid in the eleventh cycle of the access, that is ten cycles after the request cycle. The controller is a four-state machine: IDLE accepts a command. IDLE goes to ISSUE for a non-zero length and straight to DONE for a zero length. ISSUE goes to DRAIN once the last element has been requested. DRAIN goes to DONE when the last element has completed. DONE returns to IDLE after one cycle.

Top module: `svmu_top`

## Requirements
- R1: After reset, done_o is low and no bank request is raised.
- R2: A command moves exactly the number of elements held in the length register. A length written above 64 is held as 64.
- R3: With a length of zero, a command raises done_o in the cycle right after the accepting edge and issues no bank request.
- R4: Element i goes to word address base + i*stride. Its bank is the word address modulo 16, and its in-bank address is the word address divided by 16.
- R5: At most one bank request is raised per cycle, and elements are requested in rising index order.
- R6: A bank is not requested again until eleven cycles after its previous request. With a stride of 16, consecutive elements are therefore requested eleven cycles apart.
- R7: When no element targets an occupied bank, done_o rises N+10 cycles after the accepting edge for length N.
- R8: A load writes each returned element into the named register at its own element index. done_o rises only after the last element has been written.
- R9: A store raises bank_we_o with each request and sends the named register's elements in index order. done_o follows the completion of the last bank write, which happens eleven cycles after that write's request.
- R10: done_o is a one-cycle pulse. After it, the unit accepts the next command.
- R11: cmd_op_i = 0 selects a load and cmd_op_i = 1 selects a store. cmd_vreg_i selects one of registers 0 to 7, and the other registers are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken in IDLE |
| cmd_op_i | input | 1 | 0 load, 1 store |
| cmd_base_i | input | 20 | Base word address |
| cmd_vreg_i | input | 3 | Vector register selector |
| vlen_we_i | input | 1 | Length register write strobe |
| vlen_i | input | 8 | Length value, clamped to 64 |
| vstride_we_i | input | 1 | Stride register write strobe |
| vstride_i | input | 20 | Stride in words |
| done_o | output | 1 | One-cycle completion pulse |
| bank_req_o | output | 16 | Per-bank request valid |
| bank_we_o | output | 1 | Write enable for the requested bank |
| bank_addr_o | output | 16 | In-bank word address |
| bank_wdata_o | output | 64 | Store data |
| bank_rvalid_i | input | 16 | Per-bank read return valid |
| bank_rdata_i | input | 1024 | Per-bank read data, bank b at bits 64b+63..64b |

## Verification
Let E0 be the edge that accepts the command. Element requests then appear from the cycle after E0. done_o is due after edge E0+N+10 for conflict-free strides, after edge E0 for a zero length, after edge E0+44 for four elements at stride 16, and after edge E0+29 for sixteen elements at stride 2. The bench counts falling edges from E0 and compares the count at which done_o first appears with these values, then checks that done_o has dropped one cycle later. A bench bank model returns data derived from each word address ten edges after the request, records every request, and flags any request that reaches a bank still inside its eleven-cycle window. Data loaded into each register is checked by storing that register back out and comparing the recorded write data and addresses element by element.

// File: rtl/svmu_pkg.sv
package svmu_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_DRAIN = 2'd2,
        S_DONE  = 2'd3
    } svmu_state_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } svmu_op_e;
endpackage

// File: rtl/svmu_addr_gen.sv
module svmu_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o   <= '0;
            idx_o    <= '0;
            stride_q <= '0;
        end else if (start_i) begin
            addr_o   <= base_i;
            idx_o    <= '0;
            stride_q <= stride_i;
        end else if (step_i) begin
            addr_o <= addr_o + stride_q;
            idx_o  <= idx_o + IDX_W'(1);
        end
    end
endmodule

// File: rtl/svmu_bank_tracker.sv
module svmu_bank_tracker #(
    parameter int NB    = 16,
    parameter int LAT   = 11,
    parameter int IDX_W = 7,
    localparam int BB    = $clog2(NB),
    localparam int CNT_W = $clog2(LAT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [BB-1:0]    issue_bank_i,
    input  logic [IDX_W-1:0] issue_idx_i,
    input  logic             issue_store_i,
    input  logic [NB-1:0]    rvalid_i,
    output logic [NB-1:0]    free_o,
    output logic [NB-1:0]    cmp_sel_o,
    output logic             cmp_evt_o,
    output logic [IDX_W-1:0] cmp_idx_o
);
    logic [CNT_W-1:0] busy_q [NB];
    logic [IDX_W-1:0] tag_q  [NB];
    logic [NB-1:0]    pend_q;
    logic [NB-1:0]    st_q;

    always_comb begin
        cmp_idx_o = '0;
        for (int b = 0; b < NB; b++) begin
            free_o[b]    = (busy_q[b] == '0);
            cmp_sel_o[b] = pend_q[b] && (st_q[b] ? (busy_q[b] == CNT_W'(1)) : rvalid_i[b]);
            if (cmp_sel_o[b]) cmp_idx_o = cmp_idx_o | tag_q[b];
        end
        cmp_evt_o = |cmp_sel_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            st_q   <= '0;
            for (int b = 0; b < NB; b++) begin
                busy_q[b] <= '0;
                tag_q[b]  <= '0;
            end
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (issue_i && issue_bank_i == BB'(b)) begin
                    busy_q[b] <= CNT_W'(LAT - 1);
                    pend_q[b] <= 1'b1;
                    st_q[b]   <= issue_store_i;
                    tag_q[b]  <= issue_idx_i;
                end else begin
                    if (busy_q[b] != '0) busy_q[b] <= busy_q[b] - CNT_W'(1);
                    if (cmp_sel_o[b])    pend_q[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/svmu_vrf.sv
module svmu_vrf #(
    parameter int NREG  = 8,
    parameter int DEPTH = 64,
    parameter int W     = 64,
    localparam int RW = $clog2(NREG),
    localparam int EW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [RW-1:0] wreg_i,
    input  logic [EW-1:0] widx_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [RW-1:0] rreg_i,
    input  logic [EW-1:0] ridx_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [NREG*DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[int'(wreg_i) * DEPTH + int'(widx_i)] <= wdata_i;
    end

    assign rdata_o = mem[int'(rreg_i) * DEPTH + int'(ridx_i)];
endmodule

// File: rtl/svmu_top.sv
module svmu_top #(
    parameter int NUM_BANKS = 16,
    parameter int BANK_LAT  = 11,
    parameter int NUM_VREGS = 8,
    parameter int MAX_VLEN  = 64,
    parameter int ELEM_W    = 64,
    parameter int ADDR_W    = 20,
    parameter int LEN_W     = 8,
    localparam int BB    = $clog2(NUM_BANKS),
    localparam int INB_W = ADDR_W - BB,
    localparam int IDX_W = $clog2(MAX_VLEN) + 1,
    localparam int EW    = $clog2(MAX_VLEN),
    localparam int RW    = $clog2(NUM_VREGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid_i,
    input  logic                        cmd_op_i,
    input  logic [ADDR_W-1:0]           cmd_base_i,
    input  logic [RW-1:0]               cmd_vreg_i,
    input  logic                        vlen_we_i,
    input  logic [LEN_W-1:0]            vlen_i,
    input  logic                        vstride_we_i,
    input  logic [ADDR_W-1:0]           vstride_i,
    output logic                        done_o,
    output logic [NUM_BANKS-1:0]        bank_req_o,
    output logic                        bank_we_o,
    output logic [INB_W-1:0]            bank_addr_o,
    output logic [ELEM_W-1:0]           bank_wdata_o,
    input  logic [NUM_BANKS-1:0]        bank_rvalid_i,
    input  logic [NUM_BANKS*ELEM_W-1:0] bank_rdata_i
);
    import svmu_pkg::*;

    svmu_state_e      state_q, state_d;
    svmu_op_e         op_q;
    logic [RW-1:0]    vreg_q;
    logic [IDX_W-1:0] len_q, run_len_q, cmp_cnt_q;
    logic [ADDR_W-1:0] stride_q;

    logic             accept, can_issue, last_issue;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0] cur_idx;
    logic [BB-1:0]    cur_bank;
    logic [NUM_BANKS-1:0] bank_free, cmp_sel;
    logic             cmp_evt;
    logic [IDX_W-1:0] cmp_idx;
    logic [ELEM_W-1:0] ld_data, rf_rdata;
    logic             rf_we;

    assign accept     = (state_q == S_IDLE) && cmd_valid_i;
    assign cur_bank   = cur_addr[BB-1:0];
    assign can_issue  = (state_q == S_ISSUE) && bank_free[cur_bank];
    assign last_issue = can_issue && ((cur_idx + IDX_W'(1)) == run_len_q);
    assign rf_we      = cmp_evt && (op_q == OP_LOAD);

    // Programmable registers and per-command latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            stride_q  <= '0;
            run_len_q <= '0;
            op_q      <= OP_LOAD;
            vreg_q    <= '0;
            cmp_cnt_q <= '0;
        end else begin
            if (vlen_we_i)
                len_q <= (vlen_i > LEN_W'(MAX_VLEN)) ? IDX_W'(MAX_VLEN) : vlen_i[IDX_W-1:0];
            if (vstride_we_i) stride_q <= vstride_i;
            if (accept) begin
                run_len_q <= len_q;
                op_q      <= svmu_op_e'(cmd_op_i);
                vreg_q    <= cmd_vreg_i;
                cmp_cnt_q <= '0;
            end else if (cmp_evt) begin
                cmp_cnt_q <= cmp_cnt_q + IDX_W'(1);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid_i) state_d = (len_q == '0) ? S_DONE : S_ISSUE;
            S_ISSUE: if (last_issue) state_d = S_DRAIN;
            S_DRAIN: if (cmp_evt && ((cmp_cnt_q + IDX_W'(1)) == run_len_q)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        done_o       = (state_q == S_DONE);
        bank_req_o   = can_issue ? (NUM_BANKS'(1) << cur_bank) : '0;
        bank_we_o    = can_issue && (op_q == OP_STORE);
        bank_addr_o  = cur_addr[ADDR_W-1:BB];
        bank_wdata_o = rf_rdata;
    end

    // Return data select
    always_comb begin
        ld_data = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (cmp_sel[b]) ld_data = ld_data | bank_rdata_i[b*ELEM_W +: ELEM_W];
    end

    svmu_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .base_i(cmd_base_i),
        .stride_i(stride_q), .step_i(can_issue), .addr_o(cur_addr), .idx_o(cur_idx)
    );

    svmu_bank_tracker #(.NB(NUM_BANKS), .LAT(BANK_LAT), .IDX_W(IDX_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .issue_i(can_issue), .issue_bank_i(cur_bank),
        .issue_idx_i(cur_idx), .issue_store_i(op_q == OP_STORE), .rvalid_i(bank_rvalid_i),
        .free_o(bank_free), .cmp_sel_o(cmp_sel), .cmp_evt_o(cmp_evt), .cmp_idx_o(cmp_idx)
    );

    svmu_vrf #(.NREG(NUM_VREGS), .DEPTH(MAX_VLEN), .W(ELEM_W)) u_vrf (
        .clk(clk), .we_i(rf_we), .wreg_i(vreg_q), .widx_i(cmp_idx[EW-1:0]), .wdata_i(ld_data),
        .rreg_i(vreg_q), .ridx_i(cur_idx[EW-1:0]), .rdata_o(rf_rdata)
    );
endmodule

// File: rtl/svmu_checker.sv
module svmu_checker #(
    parameter int NB       = 16,
    parameter int LAT      = 11,
    parameter int IDX_W    = 7,
    parameter int MAX_VLEN = 64,
    localparam int CW = $clog2(LAT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NB-1:0]    bank_req,
    input logic             done,
    input logic [IDX_W-1:0] run_len
);
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_req) <= 1); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bank_req == '0)); // R8

    AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= IDX_W'(MAX_VLEN)); // R2

    for (genvar b = 0; b < NB; b++) begin : g_gap
        logic [CW-1:0] gap_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            gap_q <= '0;
            else if (bank_req[b])  gap_q <= CW'(LAT - 1);
            else if (gap_q != '0)  gap_q <= gap_q - CW'(1);
        end
        AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            bank_req[b] |-> (gap_q == '0)); // R6
    end
endmodule

bind svmu_top svmu_checker #(
    .NB(NUM_BANKS), .LAT(BANK_LAT), .IDX_W(IDX_W), .MAX_VLEN(MAX_VLEN)
) u_svmu_chk (
    .clk(clk), .rst_n(rst_n), .bank_req(bank_req_o), .done(done_o), .run_len(run_len_q)
);

// File: tb/test_svmu_top.sv
`timescale 1ns/1ps
module test_svmu_top;
    localparam int NB = 16;
    localparam int EW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [19:0] cmd_base = '0;
    logic [2:0]  cmd_vreg = '0;
    logic vlen_we = 1'b0, vstride_we = 1'b0;
    logic [7:0]  vlen = '0;
    logic [19:0] vstride = '0;
    logic done;
    logic [NB-1:0] bank_req, bank_rvalid;
    logic bank_we;
    logic [15:0] bank_addr;
    logic [EW-1:0] bank_wdata;
    logic [NB*EW-1:0] bank_rdata;

    int checks = 0, fails = 0;
    int cnt [NB];
    int la  [NB];
    bit ld  [NB];
    int log_addr [64];
    logic [EW-1:0] log_data [64];
    int log_n = 0, req_total = 0, conflicts = 0;

    always #2.5 clk = ~clk;

    svmu_top i_svmu_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_base_i(cmd_base), .cmd_vreg_i(cmd_vreg), .vlen_we_i(vlen_we), .vlen_i(vlen),
        .vstride_we_i(vstride_we), .vstride_i(vstride), .done_o(done),
        .bank_req_o(bank_req), .bank_we_o(bank_we), .bank_addr_o(bank_addr),
        .bank_wdata_o(bank_wdata), .bank_rvalid_i(bank_rvalid), .bank_rdata_i(bank_rdata)
    );

    function automatic logic [EW-1:0] pat(input int w);
        return 64'h5A5A_0000_0000_0000 ^ (64'(w) * 64'h0000_0001_0001_0003);
    endfunction

    // Bank model: data returns ten edges after the request edge
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_rvalid[b] = ld[b] && (cnt[b] == 1);
            bank_rdata[b*EW +: EW] = pat(la[b] * NB + b);
        end
    end

    always @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (rst_n && bank_req[b]) begin
                if (cnt[b] != 0) conflicts <= conflicts + 1;
                cnt[b] <= 10;
                la[b]  <= int'(bank_addr);
                ld[b]  <= !bank_we;
                if (log_n < 64) begin
                    log_addr[log_n] <= int'(bank_addr) * NB + b;
                    log_data[log_n] <= bank_wdata;
                end
                log_n     <= log_n + 1;
                req_total <= req_total + 1;
            end else if (cnt[b] > 0) begin
                cnt[b] <= cnt[b] - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_len(input int v);
        @(negedge clk); vlen = 8'(v); vlen_we = 1'b1;
        @(negedge clk); vlen_we = 1'b0;
    endtask

    task automatic set_stride(input int s);
        @(negedge clk); vstride = 20'(s); vstride_we = 1'b1;
        @(negedge clk); vstride_we = 1'b0;
    endtask

    // Returns the falling-edge count after the accepting edge at which done is first seen
    task automatic run_cmd(input bit op, input int base, input int vreg, output int edges);
        int j;
        @(negedge clk);
        log_n = 0; req_total = 0;
        cmd_valid = 1'b1; cmd_op = op; cmd_base = 20'(base); cmd_vreg = 3'(vreg);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        j = 0;
        while (!done && j < 3000) begin
            @(negedge clk);
            j++;
        end
        edges = j;
        @(negedge clk);
        chk(!done, "R10 done pulse length", longint'(done), 0);
    endtask

    task automatic check_log(input string tag, input int n, input int base, input int stride,
                             input bit data_chk, input int dbase, input int dstride);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        chk(log_n == n, {tag, " request count"}, log_n, n);
        for (int i = 0; i < n && i < 64; i++) begin
            if (log_addr[i] != base + i * stride ||
                (data_chk && log_data[i] != pat(dbase + i * dstride))) begin
                if (bad == 0) begin first_act = log_addr[i]; first_exp = base + i * stride; end
                bad++;
            end
        end
        chk(bad == 0, {tag, " element address/data"}, first_act, first_exp);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1 done after reset", longint'(done), 0);
        chk(bank_req == '0, "R1 request after reset", longint'(bank_req), 0);
    endtask

    task automatic t_unit();
        int e;
        set_len(50); set_stride(1);
        run_cmd(1'b0, 100, 1, e);                       // R11 op 0 = load
        chk(e == 60, "R7 unit-stride load done cycle", e, 60);
        check_log("R4 unit load", 50, 100, 1, 1'b0, 0, 0);
        run_cmd(1'b1, 3000, 1, e);                      // R11 op 1 = store
        chk(e == 60, "R9 unit-stride store done cycle", e, 60);
        check_log("R8 R9 unit store", 50, 3000, 1, 1'b1, 100, 1);
    endtask

    task automatic t_stride16();
        int e;
        set_len(4); set_stride(16);
        run_cmd(1'b0, 5, 2, e);
        chk(e == 44, "R6 stride-16 serialised done cycle", e, 44);
        check_log("R4 stride-16 load", 4, 5, 16, 1'b0, 0, 0);
        chk(conflicts == 0, "R6 busy bank requested", conflicts, 0);
    endtask

    task automatic t_stride2();
        int e;
        set_len(16); set_stride(2);
        run_cmd(1'b0, 0, 3, e);
        chk(e == 29, "R6 stride-2 partial stall done cycle", e, 29);
        set_stride(3);
        run_cmd(1'b1, 500, 3, e);
        chk(e == 26, "R7 stride-3 store done cycle", e, 26);
        check_log("R8 stride-2 load into v3", 16, 500, 3, 1'b1, 0, 2);
        set_stride(1);
        run_cmd(1'b1, 900, 1, e);
        check_log("R11 v1 untouched by v3 load", 16, 900, 1, 1'b1, 100, 1);
        chk(conflicts == 0, "R6 busy bank requested", conflicts, 0);
    endtask

    task automatic t_zero();
        int e;
        set_len(0);
        run_cmd(1'b0, 77, 4, e);
        chk(e == 0, "R3 zero-length done cycle", e, 0);
        chk(req_total == 0, "R3 zero-length requests", req_total, 0);
    endtask

    task automatic t_clamp();
        int e;
        set_len(100); set_stride(1);
        run_cmd(1'b0, 40, 7, e);
        chk(e == 74, "R2 clamped load done cycle", e, 74);
        check_log("R2 clamped load", 64, 40, 1, 1'b0, 0, 0);
        run_cmd(1'b1, 7000, 7, e);
        chk(e == 74, "R9 clamped store done cycle", e, 74);
        check_log("R2 clamped store", 64, 7000, 1, 1'b1, 40, 1);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin cnt[b] = 0; la[b] = 0; ld[b] = 1'b0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unit();
        t_stride16();
        t_stride2();
        t_zero();
        t_clamp();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule